// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block holds the program counter of a small 16-bit processor and works out where the next instruction comes from. A fetch strobe moves the counter one word forward. An execute strobe then looks at the control-flow opcode held in the instruction word and may redirect the counter. There are three redirect sources. The first is an adder that adds a sign-extended 9-bit displacement to the already-incremented counter, for conditional branches. The second is a register value, for register jumps. The third is a value taken from the shared bus, for service-routine calls.

Conditional branches are resolved against the stored negative, zero and positive flags. The instruction carries a three-bit mask, and the branch is taken when any masked flag is set. Service calls also produce a memory address: the zero-extended 8-bit vector from the instruction word. The surrounding control logic reads the vector table at this address, and the value read comes back on the bus input. A one-cycle `redirect` output tells the rest of the pipeline that the sequential path was abandoned.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low the counter is set to the parameter `RESET_PC` (default 0x3000), and `redirect` is low whenever `exec_en` is low.
- R2: `fetch_en` alone adds one to the counter at the next clock edge, wrapping from 0xFFFF to 0x0000.
- R3: Opcode IR[15:12]=0000 is a conditional branch. Its mask is IR[11:9]. Mask bit 11 selects the negative flag `cc_nzp[2]`, bit 10 selects zero `cc_nzp[1]`, and bit 9 selects positive `cc_nzp[0]`. When mask AND flags is non-zero, the execute strobe loads the counter with the counter plus sign-extended IR[8:0], modulo 2^16.
- R4: A branch whose mask matches no set flag leaves the counter unchanged. A mask of 000 is never taken, and a mask of 111 is always taken with any single set flag.
- R5: Opcode 1100 is a register jump. It loads the counter from `jmp_base`. `jmp_reg_idx` always shows IR[8:6], the register the caller must supply.
- R6: Opcode 1111 is a service call. It loads the counter from `bus_val`.
- R7: `trap_addr` always equals IR[7:0] zero-extended to 16 bits. IR[15:8] has no influence on it.
- R8: `redirect` is high during an execute cycle exactly when the counter is loaded from a source other than the increment.
- R9: An execute strobe with any other opcode leaves the counter unchanged and keeps `redirect` low.
- R10: When both strobes are high, a redirect takes precedence over the increment. Without a redirect, the counter still increments.
- R11: With neither strobe high, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_en | input | 1 | Fetch-stage strobe: increment the counter |
| exec_en | input | 1 | Execute-stage strobe: resolve control flow |
| insn | input | 16 | Current instruction word |
| jmp_base | input | 16 | Register value for register jumps |
| bus_val | input | 16 | Shared-bus value for service calls |
| cc_nzp | input | 3 | Stored flags {negative, zero, positive} |
| pc | output | 16 | Current program counter |
| trap_addr | output | 16 | Zero-extended service vector address |
| jmp_reg_idx | output | 3 | Register index field of a register jump |
| redirect | output | 1 | High in an execute cycle that leaves the sequential path |

## Verification
Branches are tried with each single-flag mask against a matching and a non-matching flag. These cases show whether the mask bits are wired to the right flags. An empty mask and a full mask separate the "never" case from the "always" case. Negative offsets, the largest positive offset and a target that crosses 0xFFFF test the sign extension and the wrap. Jumps, service calls, a non-control opcode and both strobes together show whether the source multiplexer and its priority pick the right input.

// File: rtl/npc_pkg.sv
package npc_pkg;

   localparam int unsigned INSN_W = 16;
   localparam int unsigned OPC_W  = 4;

   localparam logic [OPC_W-1:0] OPC_BRANCH = 4'b0000;
   localparam logic [OPC_W-1:0] OPC_JUMP   = 4'b1100;
   localparam logic [OPC_W-1:0] OPC_SVC    = 4'b1111;

   typedef enum logic [1:0] {
      SRC_SEQ   = 2'd0,
      SRC_ADDER = 2'd1,
      SRC_REG   = 2'd2,
      SRC_BUS   = 2'd3
   } pc_src_e;

endpackage

// File: rtl/npc_cond.sv
module npc_cond #(
   parameter int unsigned MASK_W = 3
) (
   input  logic [MASK_W-1:0] mask,
   input  logic [MASK_W-1:0] flags,
   output logic              take
);
   logic [MASK_W-1:0] hit;

   for (genvar i = 0; i < MASK_W; i++) begin : g_bit
      assign hit[i] = mask[i] & flags[i];
   end

   assign take = |hit;
endmodule

// File: rtl/npc_addr.sv
module npc_addr #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned OFF_W  = 9
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFF_W-1:0]  disp,
   output logic [ADDR_W-1:0] target
);
   localparam int unsigned EXT_W = ADDR_W - OFF_W;

   logic [ADDR_W-1:0] disp_ext;

   if (EXT_W == 0) begin : g_noext
      assign disp_ext = disp;
   end else begin : g_sext
      assign disp_ext = {{EXT_W{disp[OFF_W-1]}}, disp};
   end

   assign target = base + disp_ext;
endmodule

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
#(
   parameter int unsigned MASK_W = 3
) (
   input  logic [INSN_W-1:0] insn,
   input  logic [MASK_W-1:0] flags,
   output pc_src_e           src
);
   localparam int unsigned MASK_LSB = 9;

   logic [OPC_W-1:0]  opc;
   logic [MASK_W-1:0] mask;
   logic              br_take;

   assign opc  = insn[INSN_W-1 -: OPC_W];
   assign mask = insn[MASK_LSB +: MASK_W];

   npc_cond #(.MASK_W(MASK_W)) u_cond (
      .mask  (mask),
      .flags (flags),
      .take  (br_take)
   );

   always_comb begin
      src = SRC_SEQ;
      unique case (opc)
         OPC_BRANCH: src = br_take ? SRC_ADDER : SRC_SEQ;
         OPC_JUMP:   src = SRC_REG;
         OPC_SVC:    src = SRC_BUS;
         default:    src = SRC_SEQ;
      endcase
   end
endmodule

// File: rtl/npc_sel.sv
module npc_sel
   import npc_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  pc_src_e           src,
   input  logic              fetch_en,
   input  logic              exec_en,
   input  logic [ADDR_W-1:0] pc_inc,
   input  logic [ADDR_W-1:0] adder,
   input  logic [ADDR_W-1:0] reg_val,
   input  logic [ADDR_W-1:0] bus_val,
   output logic              load,
   output logic              redir,
   output logic [ADDR_W-1:0] next_pc
);
   assign redir = exec_en && (src != SRC_SEQ);
   assign load  = redir || fetch_en;

   always_comb begin
      next_pc = pc_inc;
      if (redir) begin
         unique case (src)
            SRC_ADDER: next_pc = adder;
            SRC_REG:   next_pc = reg_val;
            SRC_BUS:   next_pc = bus_val;
            default:   next_pc = pc_inc;
         endcase
      end
   end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned OFF_W    = 9,
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned MASK_W   = 3,
   parameter logic [ADDR_W-1:0] RESET_PC = 16'h3000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_en,
   input  logic              exec_en,
   input  logic [15:0]       insn,
   input  logic [ADDR_W-1:0] jmp_base,
   input  logic [ADDR_W-1:0] bus_val,
   input  logic [MASK_W-1:0] cc_nzp,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] trap_addr,
   output logic [2:0]        jmp_reg_idx,
   output logic              redirect
);
   localparam int unsigned VEC_PAD = ADDR_W - VEC_W;
   localparam int unsigned BASE_LSB = 6;

   if (OFF_W < 2 || OFF_W > 9) begin : g_bad_off
      $error("npc_unit: OFF_W must be 2..9");
   end
   if (MASK_W != 3) begin : g_bad_mask
      $error("npc_unit: MASK_W must be 3");
   end
   if (VEC_W < 1 || VEC_W > 8 || VEC_W > ADDR_W) begin : g_bad_vec
      $error("npc_unit: VEC_W must be 1..8 and not above ADDR_W");
   end
   if (ADDR_W < OFF_W) begin : g_bad_addr
      $error("npc_unit: ADDR_W must cover OFF_W");
   end

   pc_src_e           src;
   logic              load;
   logic [ADDR_W-1:0] pc_inc;
   logic [ADDR_W-1:0] br_target;
   logic [ADDR_W-1:0] next_pc;

   assign pc_inc = pc + ADDR_W'(1);

   npc_decode #(.MASK_W(MASK_W)) u_dec (
      .insn  (insn),
      .flags (cc_nzp),
      .src   (src)
   );

   npc_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
      .base   (pc),
      .disp   (insn[OFF_W-1:0]),
      .target (br_target)
   );

   npc_sel #(.ADDR_W(ADDR_W)) u_sel (
      .src      (src),
      .fetch_en (fetch_en),
      .exec_en  (exec_en),
      .pc_inc   (pc_inc),
      .adder    (br_target),
      .reg_val  (jmp_base),
      .bus_val  (bus_val),
      .load     (load),
      .redir    (redirect),
      .next_pc  (next_pc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc <= RESET_PC;
      end else if (load) begin
         pc <= next_pc;
      end
   end

   if (VEC_PAD == 0) begin : g_vec_full
      assign trap_addr = insn[VEC_W-1:0];
   end else begin : g_vec_zext
      assign trap_addr = {{VEC_PAD{1'b0}}, insn[VEC_W-1:0]};
   end

   assign jmp_reg_idx = insn[BASE_LSB +: 3];
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned MASK_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_en,
   input logic              exec_en,
   input logic [15:0]       insn,
   input logic [ADDR_W-1:0] jmp_base,
   input logic [ADDR_W-1:0] bus_val,
   input logic [ADDR_W-1:0] pc,
   input logic [ADDR_W-1:0] trap_addr,
   input logic              redirect
);
   // R2
   fetch_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_en && !exec_en) |=> pc == ADDR_W'($past(pc) + ADDR_W'(1)));

   // R5
   jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && insn[15:12] == 4'b1100) |=> pc == $past(jmp_base));

   // R6
   svc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && insn[15:12] == 4'b1111) |=> pc == $past(bus_val));

   // R4
   empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && !fetch_en && insn[15:9] == 7'b0) |=> $stable(pc));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec_en && !fetch_en) |=> $stable(pc));

   // R8
   quiet_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |-> !redirect);

   // R7
   vec_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_addr[ADDR_W-1:8] == '0);
endmodule

bind npc_unit npc_unit_chk #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fetch_en  (fetch_en),
   .exec_en   (exec_en),
   .insn      (insn),
   .jmp_base  (jmp_base),
   .bus_val   (bus_val),
   .pc        (pc),
   .trap_addr (trap_addr),
   .redirect  (redirect)
);

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        fetch_en, exec_en;
   logic [15:0] insn, jmp_base, bus_val;
   logic [2:0]  cc_nzp;
   logic [15:0] pc, trap_addr;
   logic [2:0]  jmp_reg_idx;
   logic        redirect;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   npc_unit u_dut (
      .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .exec_en(exec_en),
      .insn(insn), .jmp_base(jmp_base), .bus_val(bus_val), .cc_nzp(cc_nzp),
      .pc(pc), .trap_addr(trap_addr), .jmp_reg_idx(jmp_reg_idx),
      .redirect(redirect)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one clock: drive, sample combinational outputs, take the edge, settle
   task automatic step(input logic f, input logic e, input logic [15:0] ir,
                       input logic [15:0] jb, input logic [15:0] bv,
                       input logic [2:0] cc, output logic bt);
      fetch_en = f; exec_en = e; insn = ir; jmp_base = jb; bus_val = bv; cc_nzp = cc;
      #1;
      bt = redirect;
      @(posedge clk);
      #1;
      fetch_en = 1'b0; exec_en = 1'b0;
   endtask

   task automatic set_pc(input logic [15:0] v);
      logic bt;
      step(1'b0, 1'b1, 16'hC000, v, 16'h0, 3'b010, bt);
   endtask

   task automatic t_reset;
      check("R1 reset pc", pc, 16'h3000);
      check("R1 redirect idle", {15'b0, redirect}, 16'h0);
   endtask

   task automatic t_fetch;
      logic bt;
      step(1'b1, 1'b0, 16'h1000, 16'h0, 16'h0, 3'b010, bt);
      check("R2 increment", pc, 16'h3001);
      set_pc(16'hFFFF);
      step(1'b1, 1'b0, 16'h1000, 16'h0, 16'h0, 3'b010, bt);
      check("R2 wrap", pc, 16'h0000);
   endtask

   task automatic t_branch;
      logic bt;
      set_pc(16'h3001);
      // n mask, n flag, offset -2
      step(1'b0, 1'b1, {4'b0000, 3'b100, 9'h1FE}, 16'h0, 16'h0, 3'b100, bt);
      check("R3 n taken pc", pc, 16'h2FFF);
      check("R8 taken redirect", {15'b0, bt}, 16'h1);
      // z mask, p flag: not taken
      step(1'b0, 1'b1, {4'b0000, 3'b010, 9'h010}, 16'h0, 16'h0, 3'b001, bt);
      check("R4 mismatch pc", pc, 16'h2FFF);
      check("R8 not taken redirect", {15'b0, bt}, 16'h0);
      // p mask, p flag, offset +255
      step(1'b0, 1'b1, {4'b0000, 3'b001, 9'h0FF}, 16'h0, 16'h0, 3'b001, bt);
      check("R3 p taken max", pc, 16'h30FE);
      // z mask, z flag, offset -256
      step(1'b0, 1'b1, {4'b0000, 3'b010, 9'h100}, 16'h0, 16'h0, 3'b010, bt);
      check("R3 z taken min", pc, 16'h2FFE);
      // empty mask never taken
      step(1'b0, 1'b1, {4'b0000, 3'b000, 9'h005}, 16'h0, 16'h0, 3'b100, bt);
      check("R4 empty mask", pc, 16'h2FFE);
      // full mask with n flag
      step(1'b0, 1'b1, {4'b0000, 3'b111, 9'h002}, 16'h0, 16'h0, 3'b100, bt);
      check("R4 full mask", pc, 16'h3000);
      // wrap across top
      set_pc(16'hFFF0);
      step(1'b0, 1'b1, {4'b0000, 3'b111, 9'h020}, 16'h0, 16'h0, 3'b001, bt);
      check("R3 wrap target", pc, 16'h0010);
   endtask

   task automatic t_jump;
      logic bt;
      step(1'b0, 1'b1, {4'b1100, 3'b000, 3'b101, 6'b0}, 16'hBEEF, 16'h1111, 3'b010, bt);
      check("R5 jump pc", pc, 16'hBEEF);
      check("R8 jump redirect", {15'b0, bt}, 16'h1);
      insn = {4'b1100, 3'b000, 3'b110, 6'b0};
      #1;
      check("R5 base index", {13'b0, jmp_reg_idx}, 16'h0006);
   endtask

   task automatic t_svc;
      logic bt;
      insn = 16'hF025;
      #1;
      check("R7 vector", trap_addr, 16'h0025);
      insn = 16'hFFFF;
      #1;
      check("R7 high bits ignored", trap_addr, 16'h00FF);
      step(1'b0, 1'b1, 16'hF025, 16'h2222, 16'h0400, 3'b010, bt);
      check("R6 svc pc", pc, 16'h0400);
      check("R8 svc redirect", {15'b0, bt}, 16'h1);
   endtask

   task automatic t_other;
      logic bt;
      step(1'b0, 1'b1, 16'h1FFF, 16'h5555, 16'h6666, 3'b111, bt);
      check("R9 other opcode pc", pc, 16'h0400);
      check("R9 other redirect", {15'b0, bt}, 16'h0);
   endtask

   task automatic t_both;
      logic bt;
      step(1'b1, 1'b1, 16'hC000, 16'h7000, 16'h0, 3'b010, bt);
      check("R10 redirect wins", pc, 16'h7000);
      step(1'b1, 1'b1, 16'h5000, 16'h1234, 16'h0, 3'b010, bt);
      check("R10 increment kept", pc, 16'h7001);
   endtask

   task automatic t_idle;
      logic bt;
      step(1'b0, 1'b0, 16'hC000, 16'h9999, 16'h8888, 3'b111, bt);
      check("R11 hold", pc, 16'h7001);
      check("R1 no exec redirect", {15'b0, bt}, 16'h0);
   endtask

   initial begin
      rst_n = 1'b0; fetch_en = 1'b0; exec_en = 1'b0;
      insn = 16'h0; jmp_base = 16'h0; bus_val = 16'h0; cc_nzp = 3'b010;
      repeat (3) @(posedge clk);
      #1;
      t_reset;
      rst_n = 1'b1;
      t_fetch;
      t_branch;
      t_jump;
      t_svc;
      t_other;
      t_both;
      t_idle;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule